// File: doc/BRIEF.md
# Two-Wire 16-Bit Port Expander Target

This block is a target on a two-wire serial bus (I2C) that drives two 8-bit general-purpose ports and reads them back. A controller addresses it with a 7-bit address. The upper four bits of that address are fixed at binary 0100 and the lower three come from strap pins. A write transfer sends bytes that land alternately in the low port latch and the high port latch. A read transfer returns the sampled pin levels in the same alternating order. The serial lines are open-drain. The block takes the sensed line level in and gives out a pull-low enable for SDA.

An interrupt line, also open-drain, signals that the pins have changed since the controller last looked at them. Any read of the pins, or any accepted write byte, clears it. SCL and SDA are oversampled on the block clock through a short synchronizer. Start and stop conditions and clock edges are all detected in that clock domain.

Top module: `expTop`

## Requirements
- R1: After reset all 16 port latches are 1, SDA is not pulled low and the interrupt line is not pulled low.
- R2: The address byte is acknowledged only when its upper seven bits equal 0100 followed by the strap value (bit order strap[2], strap[1], strap[0]). On any other address the target gives no acknowledge and ignores all later bytes until the next start condition.
- R3: Bit 0 of the address byte selects the direction (0 = write, 1 = read). In a write, the first data byte updates portOut[7:0], the second updates portOut[15:8], and later bytes keep alternating low, high. Each byte is received most significant bit first.
- R4: The target pulls SDA low during the acknowledge bit after a matching address byte and after every data byte written to it.
- R5: In a read, the first byte is pinIn[7:0] and the second is pinIn[15:8], most significant bit first. The pattern repeats for as long as the controller acknowledges each byte.
- R6: All 16 pins are sampled together at the acknowledge point that precedes each low-port byte. Pin changes after that point do not alter the low byte or the following high byte.
- R7: A stop condition (SDA rising while SCL is high) may end a transfer at any bit. Latches keep every byte that was already acknowledged, and a partly received byte is discarded.
- R8: A repeated start (SDA falling while SCL is high) re-decodes the address and restarts the byte order at the low port.
- R9: When the controller does not acknowledge a read byte, the target leaves SDA released for every further clock until the next start or stop.
- R10: The interrupt line is pulled low when the pins change to a value that differs from the snapshot taken at the last read. It stays low until cleared.
- R11: The interrupt is cleared by a pin read (at the address acknowledge of a read) and by each accepted write data byte.
- R12: A pin change that returns the pins to the last read snapshot does not assert the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, oversamples the bus |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Sensed SCL line level |
| sdaIn | input | 1 | Sensed SDA line level |
| sdaOe | output | 1 | 1 pulls SDA low |
| strap | input | 3 | Low three address bits |
| pinIn | input | 16 | Sensed pin levels, bit 15 = high port bit 7 |
| portOut | output | 16 | Port output latches, [7:0] low port, [15:8] high port |
| intPullLow | output | 1 | 1 pulls the interrupt line low |

## Verification
The hardest case to reach is a change on the pins that lands between the acknowledge point and the shifting of the byte out. On the bus, that window is only a few bit times wide. The bench drives the bus from tasks that step SCL and SDA at the bit level. It can therefore change pinIn after the address acknowledge and before the first read bit, then check that both returned bytes still carry the earlier value. The same bit-level control produces a stop three bits into a byte and a repeated start right after an acknowledged byte.

// File: rtl/expPkg.sv
package expPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR_BITS,
    ST_WR_ACK,
    ST_RD_BITS,
    ST_RD_ACK,
    ST_PARK
  } busState_t;

  // strobes from control to datapath, one cycle wide
  typedef struct packed {
    logic rxShift;    // shift sampled SDA into receive register
    logic txLoad;     // load next byte to send
    logic txShift;    // advance transmit register
    logic capture;    // sample all pins into snapshot
    logic latchByte;  // write received byte to selected port
    logic portHi;     // current port: 0 low, 1 high
  } strobe_t;

endpackage

// File: rtl/expSync.sv
module expSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclS,
  output logic sdaS,
  output logic sclPrev,
  output logic sdaPrev
);

  logic [STAGES-1:0] sclPipe;
  logic [STAGES-1:0] sdaPipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe[0] <= sclIn;
      sdaPipe[0] <= sdaIn;
      for (int i = 1; i < STAGES; i++) begin
        sclPipe[i] <= sclPipe[i-1];
        sdaPipe[i] <= sdaPipe[i-1];
      end
      sclPrev <= sclPipe[STAGES-1];
      sdaPrev <= sdaPipe[STAGES-1];
    end
  end

  assign sclS = sclPipe[STAGES-1];
  assign sdaS = sdaPipe[STAGES-1];

endmodule

// File: rtl/expControl.sv
module expControl
  import expPkg::*;
#(
  parameter int          PORT_W  = 8,
  parameter int          STRAP_W = 3,
  parameter logic [3:0]  ADDR_HI = 4'b0100
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sclS,
  input  logic               sdaS,
  input  logic               sclPrev,
  input  logic               sdaPrev,
  input  logic [STRAP_W-1:0] strap,
  input  logic [PORT_W-1:0]  rxByte,
  input  logic               txBit,
  output strobe_t            stb,
  output logic               sdaOe
);

  localparam int CNT_W = $clog2(PORT_W + 1);
  localparam logic [CNT_W-1:0] LAST_RX = CNT_W'(PORT_W);
  localparam logic [CNT_W-1:0] LAST_TX = CNT_W'(PORT_W - 1);

  busState_t        state;
  logic [CNT_W-1:0] bitCnt;
  logic             portHi;
  logic             ctlAck;

  logic startEv, stopEv, sclRise, sclFall, byteDone, addrHit, isRead;

  assign startEv  = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopEv   = sclS & sclPrev & ~sdaPrev & sdaS;
  assign sclRise  = sclS & ~sclPrev;
  assign sclFall  = ~sclS & sclPrev;
  assign byteDone = (bitCnt == LAST_RX);
  assign addrHit  = (rxByte[PORT_W-1:1] == {ADDR_HI, strap});
  assign isRead   = rxByte[0];

  // strobe generation
  always_comb begin
    stb        = '0;
    stb.portHi = portHi;
    if (!startEv && !stopEv) begin
      unique case (state)
        ST_ADDR: begin
          if (sclRise) stb.rxShift = 1'b1;
        end
        ST_WR_BITS: begin
          if (sclRise) stb.rxShift = 1'b1;
          if (sclFall && byteDone) stb.latchByte = 1'b1;
        end
        ST_ADDR_ACK: begin
          if (sclFall && isRead) begin
            stb.txLoad  = 1'b1;
            stb.capture = 1'b1;
          end
        end
        ST_RD_BITS: begin
          if (sclFall) stb.txShift = 1'b1;
        end
        ST_RD_ACK: begin
          if (sclFall && ctlAck) begin
            stb.txLoad  = 1'b1;
            stb.capture = portHi;
          end
        end
        default: ;
      endcase
    end
  end

  // open-drain drive
  always_comb begin
    unique case (state)
      ST_ADDR_ACK, ST_WR_ACK: sdaOe = 1'b1;
      ST_RD_BITS:             sdaOe = ~txBit;
      default:                sdaOe = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
      portHi <= 1'b0;
      ctlAck <= 1'b0;
    end else if (startEv) begin
      state  <= ST_ADDR;
      bitCnt <= '0;
      portHi <= 1'b0;
    end else if (stopEv) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
      portHi <= 1'b0;
    end else begin
      unique case (state)
        ST_ADDR: begin
          if (sclRise) bitCnt <= bitCnt + CNT_W'(1);
          if (sclFall && byteDone) begin
            bitCnt <= '0;
            state  <= addrHit ? ST_ADDR_ACK : ST_PARK;
          end
        end
        ST_ADDR_ACK: begin
          if (sclFall) state <= isRead ? ST_RD_BITS : ST_WR_BITS;
        end
        ST_WR_BITS: begin
          if (sclRise) bitCnt <= bitCnt + CNT_W'(1);
          if (sclFall && byteDone) begin
            bitCnt <= '0;
            state  <= ST_WR_ACK;
          end
        end
        ST_WR_ACK: begin
          if (sclFall) begin
            state  <= ST_WR_BITS;
            portHi <= ~portHi;
          end
        end
        ST_RD_BITS: begin
          if (sclFall) begin
            if (bitCnt == LAST_TX) begin
              bitCnt <= '0;
              state  <= ST_RD_ACK;
            end else begin
              bitCnt <= bitCnt + CNT_W'(1);
            end
          end
        end
        ST_RD_ACK: begin
          if (sclRise) ctlAck <= ~sdaS;
          if (sclFall) begin
            if (ctlAck) begin
              state  <= ST_RD_BITS;
              portHi <= ~portHi;
            end else begin
              state  <= ST_PARK;
            end
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/expDatapath.sv
module expDatapath
  import expPkg::*;
#(
  parameter int PORT_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             stb,
  input  logic                sdaS,
  input  logic [2*PORT_W-1:0] pinIn,
  output logic [PORT_W-1:0]   rxByte,
  output logic                txBit,
  output logic [2*PORT_W-1:0] portOut,
  output logic                intPullLow
);

  localparam int PINS = 2 * PORT_W;

  logic [PINS-1:0]   pinNow;
  logic [PINS-1:0]   pinPrev;
  logic [PINS-1:0]   snap;
  logic [PORT_W-1:0] txReg;
  logic              pinMoved;
  logic              pinDiffers;

  assign txBit      = txReg[PORT_W-1];
  assign pinMoved   = (pinNow != pinPrev);
  assign pinDiffers = (pinNow != snap);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pinNow  <= '1;
      pinPrev <= '1;
    end else begin
      pinNow  <= pinIn;
      pinPrev <= pinNow;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rxByte <= '0;
    else if (stb.rxShift) rxByte <= {rxByte[PORT_W-2:0], sdaS};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txReg <= '1;
      snap  <= '1;
    end else if (stb.txLoad) begin
      if (stb.capture) begin
        snap  <= pinNow;
        txReg <= pinNow[PORT_W-1:0];
      end else begin
        txReg <= snap[PINS-1:PORT_W];
      end
    end else if (stb.txShift) begin
      txReg <= {txReg[PORT_W-2:0], 1'b1};
    end
  end

  for (genvar p = 0; p < 2; p++) begin : g_port
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) portOut[p*PORT_W +: PORT_W] <= '1;
      else if (stb.latchByte && (stb.portHi == p[0]))
        portOut[p*PORT_W +: PORT_W] <= rxByte;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) intPullLow <= 1'b0;
    else if (stb.capture || stb.latchByte) intPullLow <= 1'b0;
    else if (pinMoved && pinDiffers) intPullLow <= 1'b1;
  end

endmodule

// File: rtl/expTop.sv
module expTop
  import expPkg::*;
#(
  parameter int         PORT_W      = 8,
  parameter int         STRAP_W     = 3,
  parameter logic [3:0] ADDR_HI     = 4'b0100,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sclIn,
  input  logic                sdaIn,
  output logic                sdaOe,
  input  logic [STRAP_W-1:0]  strap,
  input  logic [2*PORT_W-1:0] pinIn,
  output logic [2*PORT_W-1:0] portOut,
  output logic                intPullLow
);

  logic              sclS, sdaS, sclPrev, sdaPrev;
  logic [PORT_W-1:0] rxByte;
  logic              txBit;
  strobe_t           stb;

  expSync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclS(sclS), .sdaS(sdaS), .sclPrev(sclPrev), .sdaPrev(sdaPrev)
  );

  expControl #(.PORT_W(PORT_W), .STRAP_W(STRAP_W), .ADDR_HI(ADDR_HI)) i_ctl (
    .clk(clk), .rstN(rstN), .sclS(sclS), .sdaS(sdaS),
    .sclPrev(sclPrev), .sdaPrev(sdaPrev), .strap(strap),
    .rxByte(rxByte), .txBit(txBit), .stb(stb), .sdaOe(sdaOe)
  );

  expDatapath #(.PORT_W(PORT_W)) i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .sdaS(sdaS), .pinIn(pinIn),
    .rxByte(rxByte), .txBit(txBit), .portOut(portOut), .intPullLow(intPullLow)
  );

endmodule

// File: rtl/expChecker.sv
module expChecker
  import expPkg::*;
#(
  parameter int PINS = 16
) (
  input logic            clk,
  input logic            rstN,
  input logic            sclS,
  input logic            sdaOe,
  input logic            intPullLow,
  input logic [PINS-1:0] portOut,
  input strobe_t         stb
);

  AST_LATCH_WHILE_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(portOut) |-> !$past(sclS)); // R3

  AST_PULL_SDA_WHILE_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaOe) |-> !$past(sclS)); // R4

  AST_INT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (intPullLow && !stb.capture && !stb.latchByte) |=> intPullLow); // R10

  AST_INT_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    (stb.capture || stb.latchByte) |=> !intPullLow); // R11

endmodule

bind expTop expChecker #(.PINS(2*PORT_W)) i_chk (
  .clk(clk), .rstN(rstN), .sclS(sclS), .sdaOe(sdaOe),
  .intPullLow(intPullLow), .portOut(portOut), .stb(stb)
);

// File: tb/test_expTop.sv
module test_expTop;

  localparam int Q = 10;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [6:0] OWN_ADDR = {4'b0100, STRAP};
  localparam int NVEC = 6;
  // {address, write data (high,low), pin pattern for read-back}
  localparam logic [38:0] VEC [NVEC] = '{
    {7'h25, 16'hA55A, 16'h1234},
    {7'h25, 16'h00FF, 16'hFFFF},
    {7'h24, 16'h1111, 16'h0F0F},
    {7'h25, 16'hC3E1, 16'h8001},
    {7'h65, 16'h2222, 16'h00FE},
    {7'h25, 16'hFFFF, 16'hBEEF}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tbScl = 1'b1;
  logic        tbSdaLow = 1'b0;
  logic [15:0] pins = 16'hFFFF;
  logic        sdaOe;
  logic [15:0] portOut;
  logic        intPullLow;
  wire         sdaLine = !(tbSdaLow || sdaOe);

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  expTop i_expTop (
    .clk(clk), .rstN(rstN), .sclIn(tbScl), .sdaIn(sdaLine), .sdaOe(sdaOe),
    .strap(STRAP), .pinIn(pins), .portOut(portOut), .intPullLow(intPullLow)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    tbSdaLow = 1'b0; tick(Q);
    tbScl = 1'b1;    tick(Q);
    tbSdaLow = 1'b1; tick(Q);
    tbScl = 1'b0;    tick(Q);
  endtask

  task automatic busStop();
    tbSdaLow = 1'b1; tick(Q);
    tbScl = 1'b1;    tick(Q);
    tbSdaLow = 1'b0; tick(Q);
  endtask

  task automatic sendBit(input logic b);
    tbSdaLow = !b; tick(Q);
    tbScl = 1'b1;  tick(2*Q);
    tbScl = 1'b0;  tick(Q);
  endtask

  task automatic getBit(output logic b);
    tbSdaLow = 1'b0; tick(Q);
    tbScl = 1'b1;    tick(Q);
    b = sdaLine;     tick(Q);
    tbScl = 1'b0;    tick(Q);
  endtask

  task automatic sendByte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) sendBit(d[i]);
    getBit(b);
    ack = !b;
  endtask

  task automatic getByte(output logic [7:0] d, input logic ackIt);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      getBit(b);
      d[i] = b;
    end
    sendBit(!ackIt);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    logic        ack;
    logic [7:0]  rd;
    logic [15:0] expPort;
    tick(5);
    // R1 reset state
    check("R1 portOut", portOut, 16'hFFFF);
    check("R1 sdaOe", sdaOe, 1'b0);
    check("R1 int", intPullLow, 1'b0);
    rstN = 1'b1;
    tick(5);
    check("R1 portOut after release", portOut, 16'hFFFF);
    expPort = 16'hFFFF;

    // table walk: write a pair, then read the pins back
    for (int v = 0; v < NVEC; v++) begin
      logic [6:0]  a;
      logic [15:0] w, p;
      logic        hit;
      {a, w, p} = VEC[v];
      hit = (a == OWN_ADDR);
      busStart();
      sendByte({a, 1'b0}, ack);
      check("R2 address ack", ack, hit);
      sendByte(w[7:0], ack);
      check("R4 data ack low", ack, hit);
      sendByte(w[15:8], ack);
      check("R4 data ack high", ack, hit);
      busStop();
      if (hit) expPort = w;
      check("R3 port pair", portOut, expPort);
      pins = p;
      tick(4);
      if (hit) begin
        busStart();
        sendByte({a, 1'b1}, ack);
        check("R2 read address ack", ack, 1'b1);
        getByte(rd, 1'b1);
        check("R5 low byte", rd, p[7:0]);
        getByte(rd, 1'b0);
        check("R5 high byte", rd, p[15:8]);
        busStop();
      end
    end

    // R3 R4: four bytes alternate low, high, low, high
    busStart();
    sendByte({OWN_ADDR, 1'b0}, ack);
    sendByte(8'h11, ack); check("R4 ack byte1", ack, 1'b1);
    sendByte(8'h22, ack); check("R4 ack byte2", ack, 1'b1);
    sendByte(8'h33, ack); check("R4 ack byte3", ack, 1'b1);
    check("R3 third byte to low port", portOut, 16'h2233);
    sendByte(8'h44, ack); check("R4 ack byte4", ack, 1'b1);
    busStop();
    check("R3 alternation", portOut, 16'h4433);

    // R5 repeated pairs while acknowledged
    pins = 16'h5AC3; tick(4);
    busStart();
    sendByte({OWN_ADDR, 1'b1}, ack);
    getByte(rd, 1'b1); check("R5 repeat b0", rd, 8'hC3);
    getByte(rd, 1'b1); check("R5 repeat b1", rd, 8'h5A);
    getByte(rd, 1'b1); check("R5 repeat b2", rd, 8'hC3);
    getByte(rd, 1'b0); check("R5 repeat b3", rd, 8'h5A);
    busStop();

    // R6 pins change after the acknowledge point
    pins = 16'h1357; tick(4);
    busStart();
    sendByte({OWN_ADDR, 1'b1}, ack);
    pins = 16'hECA8;
    getByte(rd, 1'b1); check("R6 low byte from snapshot", rd, 8'h57);
    getByte(rd, 1'b0); check("R6 high byte from snapshot", rd, 8'h13);
    busStop();

    // R7 stop mid-byte keeps acknowledged bytes only
    busStart();
    sendByte({OWN_ADDR, 1'b0}, ack);
    sendByte(8'h66, ack);
    sendByte(8'h99, ack);
    busStop();
    check("R7 pair before stop", portOut, 16'h9966);
    busStart();
    sendByte({OWN_ADDR, 1'b0}, ack);
    sendByte(8'h01, ack);
    sendBit(1'b0); sendBit(1'b0); sendBit(1'b0);
    busStop();
    check("R7 partial byte dropped", portOut, 16'h9901);

    // R8 repeated start restarts at the low port
    busStart();
    sendByte({OWN_ADDR, 1'b0}, ack);
    sendByte(8'hAB, ack);
    busStart();
    sendByte({OWN_ADDR, 1'b0}, ack);
    check("R8 re-addressed ack", ack, 1'b1);
    sendByte(8'hCD, ack);
    check("R8 back to low port", portOut, 16'h99CD);
    busStart();
    sendByte({7'h26, 1'b0}, ack);
    check("R8 wrong address after restart", ack, 1'b0);
    sendByte(8'h00, ack);
    check("R2 ignored byte not acked", ack, 1'b0);
    busStop();
    check("R2 ignored byte no effect", portOut, 16'h99CD);

    // R9 controller NACK releases SDA
    pins = 16'h0000; tick(4);
    busStart();
    sendByte({OWN_ADDR, 1'b1}, ack);
    getByte(rd, 1'b0); check("R9 first byte", rd, 8'h00);
    getByte(rd, 1'b0); check("R9 released after nack", rd, 8'hFF);
    busStop();
    check("R9 sdaOe after stop", sdaOe, 1'b0);

    // R10 R11 R12 interrupt
    check("R11 cleared by read", intPullLow, 1'b0);
    pins = 16'h0010; tick(6);
    check("R10 int asserts", intPullLow, 1'b1);
    tick(50);
    check("R10 int holds", intPullLow, 1'b1);
    busStart();
    sendByte({OWN_ADDR, 1'b1}, ack);
    check("R11 read clears int", intPullLow, 1'b0);
    getByte(rd, 1'b0);
    busStop();
    pins = 16'h0011; tick(6);
    check("R10 int again", intPullLow, 1'b1);
    busStart();
    sendByte({OWN_ADDR, 1'b0}, ack);
    sendByte(8'h5F, ack);
    busStop();
    check("R11 write clears int", intPullLow, 1'b0);
    pins = 16'h0010; tick(6);
    check("R12 return to snapshot no int", intPullLow, 1'b0);
    pins = 16'h8010; tick(6);
    check("R10 new difference asserts", intPullLow, 1'b1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule